// File: doc/BRIEF.md
# Port Wakeup Edge Detector

The detector watches four input pins that are allowed to wake the chip. Each pin first passes through a two-stage synchronizer. A small per-pin state machine then tracks the synchronized level. It reports a trigger when the level moves in the direction that the pin's edge-select bit asks for: rising when the bit is 0, falling when it is 1. A trigger latches a sticky pending flag for that pin. Software clears the flag by writing 1 to it.

A single `wake` output is raised while any pending flag belongs to a pin whose enable bit is 0. The enable bits are active low, so every pin is disabled after reset. A pending flag is recorded even while its pin is disabled. The power-mode logic downstream uses `wake` as its wakeup and interrupt request.

Each level tracker has five states:
- `ST_FILL1` and `ST_FILL2` each last one cycle after reset, while the synchronizer fills.
- In `ST_SEEK`, the tracker adopts the current synchronized level without reporting a trigger.
- `ST_LOW` and `ST_HIGH` follow the level.

The transitions are fill1→fill2, fill2→seek, seek→low or seek→high, low→high on a 1 and high→low on a 0. Every other case holds the current state. A trigger is reported only on the low→high transition when the pin's edge select is 0, and only on the high→low transition when it is 1.

Top module: `pin_wake_detect`

## Requirements
- R1: Pin n (n = 0..3) owns bit n of every register. Register addresses are: 0 = enable (active low), 1 = edge select, 2 = pending, 3 = reads as 0. `reg_rdata` shows the addressed register in the same cycle. The pins behave independently, and edges on all four pins at once set all four flags.
- R2: After reset, enable reads 0xF, edge select reads 0x0, pending reads 0x0 and `wake` is 0.
- R3: With edge select 0, a rising synchronized edge sets the pin's pending flag, and a falling edge leaves it unchanged.
- R4: With edge select 1, a falling synchronized edge sets the pin's pending flag, and a rising edge leaves it unchanged.
- R5: A pin change presented before clock edge k shows on `pend_flags` after edge k+2 and not after edge k+1.
- R6: A write to address 2 clears each pending flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R7: If a qualifying edge sets a flag in the same cycle that a write clears it, the flag stays 1.
- R8: `wake` is 1 exactly when some pending flag is 1 and its enable bit is 0. A flag is still recorded while its pin is disabled.
- R9: Changing an edge-select bit while the pin holds its level sets no pending flag.
- R10: A pin level that is already present when reset is released sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 4 | Asynchronous wakeup pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Read data of the addressed register |
| pend_flags | output | 4 | Pending flags |
| wake | output | 1 | Combined wakeup request |

## Verification
A pin change made at a falling clock edge shows on `pend_flags` after the third rising edge: two edges for the synchronizer and one for the pending flop. The bench checks one cycle early, to confirm the flag is still clear, and then at the due cycle. Register writes and the resulting change in `wake` take effect at the rising edge that samples the strobe, so the bench reads them at the next falling edge. For the clear/set collision, the bench raises the clear strobe exactly across the edge on which the pending flop sets. For R3, R4 and R9, where nothing should happen, the bench waits four cycles, well past the three-edge latency, before confirming that the flags did not change.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
    typedef enum logic [2:0] {
        ST_FILL1,
        ST_FILL2,
        ST_SEEK,
        ST_LOW,
        ST_HIGH
    } lvl_state_t;

    localparam logic [1:0] ADR_ENA  = 2'd0;
    localparam logic [1:0] ADR_EDGE = 2'd1;
    localparam logic [1:0] ADR_PEND = 2'd2;
endpackage

// File: rtl/pwk_sync.sv
module pwk_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwk_edge_fsm.sv
module pwk_edge_fsm
    import pwk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic fall_sel,
    output logic evt
);
    lvl_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_FILL1;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FILL1: st_nx = ST_FILL2;
            ST_FILL2: st_nx = ST_SEEK;
            ST_SEEK:  st_nx = lvl ? ST_HIGH : ST_LOW;
            ST_LOW:   if (lvl)  st_nx = ST_HIGH;
            ST_HIGH:  if (!lvl) st_nx = ST_LOW;
            default:  st_nx = ST_FILL1;
        endcase
    end

    always_comb begin
        evt = 1'b0;
        unique case (st)
            ST_LOW:  evt = lvl && !fall_sel;
            ST_HIGH: evt = !lvl && fall_sel;
            default: evt = 1'b0;
        endcase
    end

    // R9: a trigger needs a level change, never a polarity change alone
    a_r9_stable_level_quiet: assert property (@(posedge clk) disable iff (rst)
        $stable(lvl) |-> !evt);

    // R3 / R4: the trigger direction matches the edge select
    a_r3_rise_direction: assert property (@(posedge clk) disable iff (rst)
        (evt && !fall_sel) |-> lvl);
    a_r4_fall_direction: assert property (@(posedge clk) disable iff (rst)
        (evt && fall_sel) |-> !lvl);
endmodule

// File: rtl/pwk_regs.sv
module pwk_regs
    import pwk_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [1:0]   addr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] evt,
    output logic [N-1:0] rdata,
    output logic [N-1:0] ena_n,
    output logic [N-1:0] fall_sel,
    output logic [N-1:0] pend
);
    logic [N-1:0] clr;
    logic [N-1:0] pend_nx;

    assign clr     = (we && addr == ADR_PEND) ? wdata : '0;
    assign pend_nx = (pend & ~clr) | evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_n    <= '1;
            fall_sel <= '0;
            pend     <= '0;
        end else begin
            if (we && addr == ADR_ENA)  ena_n    <= wdata;
            if (we && addr == ADR_EDGE) fall_sel <= wdata;
            pend <= pend_nx;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_ENA:  rdata = ena_n;
            ADR_EDGE: rdata = fall_sel;
            ADR_PEND: rdata = pend;
            default:  rdata = '0;
        endcase
    end

    // R2: registers hold their reset values on the first cycle after reset
    a_r2_reset_values: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ena_n == '1 && fall_sel == '0 && pend == '0));

    // R6: a written 1 clears its flag unless a trigger arrived at the same time
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
        $past(we && addr == ADR_PEND) |-> ((pend & $past(wdata & ~evt)) == '0));

    // R7: every trigger leaves its flag set, even under a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/pin_wake_detect.sv
module pin_wake_detect #(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic [NUM_PINS-1:0] pend_flags,
    output logic                wake
);
    logic [NUM_PINS-1:0] lvl_s;
    logic [NUM_PINS-1:0] evt;
    logic [NUM_PINS-1:0] ena_n;
    logic [NUM_PINS-1:0] fall_sel;

    pwk_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_s)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pwk_edge_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .lvl      (lvl_s[i]),
            .fall_sel (fall_sel[i]),
            .evt      (evt[i])
        );
    end

    pwk_regs #(.N(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .evt      (evt),
        .rdata    (reg_rdata),
        .ena_n    (ena_n),
        .fall_sel (fall_sel),
        .pend     (pend_flags)
    );

    assign wake = |(pend_flags & ~ena_n);

    // R8: with every pin disabled no wakeup can be raised
    a_r8_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        (&ena_n) |-> !wake);

    // R8: with no pending flag no wakeup can be raised
    a_r8_needs_pending: assert property (@(posedge clk) disable iff (rst)
        (pend_flags == '0) |-> !wake);
endmodule

// File: tb/pin_wake_detect_test.sv
module pin_wake_detect_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] pins;
    logic       we;
    logic [1:0] addr;
    logic [3:0] wdata;
    logic [3:0] rdata;
    logic [3:0] pend;
    logic       wake;

    always #4 clk = ~clk;

    pin_wake_detect uut (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (pins),
        .reg_we     (we),
        .reg_addr   (addr),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .pend_flags (pend),
        .wake       (wake)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] exp_q[$];
    int         src_q[$];
    string      tag_q[$];
    event       sample_ev;
    bit         done = 1'b0;

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                logic [3:0] e;
                logic [3:0] g;
                int s;
                string t;
                e = exp_q.pop_front();
                s = src_q.pop_front();
                t = tag_q.pop_front();
                case (s)
                    0:       g = rdata;
                    1:       g = pend;
                    default: g = {3'b000, wake};
                endcase
                n_chk++;
                if (g !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, g, e);
                end
            end
        end
    end

    task automatic expect_now(input int src, input logic [3:0] v, input string tag);
        exp_q.push_back(v);
        src_q.push_back(src);
        tag_q.push_back(tag);
        ->sample_ev;
    endtask

    task automatic check_reg(input logic [1:0] a, input logic [3:0] v, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        expect_now(0, v, tag);
    endtask

    task automatic check_pend(input logic [3:0] v, input string tag);
        @(negedge clk);
        #1;
        expect_now(1, v, tag);
    endtask

    task automatic check_wake(input logic v, input string tag);
        @(negedge clk);
        #1;
        expect_now(2, {3'b000, v}, tag);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        we = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pins = 4'b0101;
        we = 1'b0;
        addr = 2'd0;
        wdata = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (6) @(posedge clk);

        // R2 / R10 / R1: state after reset
        check_reg(2'd0, 4'hF, "R2 enable reset");
        check_reg(2'd1, 4'h0, "R2 edge select reset");
        check_reg(2'd2, 4'h0, "R10 no event from level at reset release");
        check_wake(1'b0, "R2 wake reset");
        check_reg(2'd3, 4'h0, "R1 unused address reads 0");

        // R3 / R5: rising edge on pin 1 with latency
        set_pins(4'b0111);
        @(posedge clk);
        @(posedge clk);
        check_pend(4'h0, "R5 not yet after second edge");
        @(posedge clk);
        check_pend(4'h2, "R3 R5 rising edge after third edge");

        // R8: gating by active-low enable
        check_wake(1'b0, "R8 pending but disabled");
        write_reg(2'd0, 4'hD);
        check_wake(1'b1, "R8 enabled pending raises wake");
        check_reg(2'd0, 4'hD, "R1 enable readback");

        // R3: falling edge ignored with select 0
        set_pins(4'b0110);
        settle();
        check_pend(4'h2, "R3 falling edge ignored");

        // R6: write-one-to-clear
        write_reg(2'd2, 4'h0);
        check_pend(4'h2, "R6 zero write keeps flag");
        write_reg(2'd2, 4'h2);
        check_pend(4'h0, "R6 one write clears flag");
        check_wake(1'b0, "R6 wake drops after clear");

        // R4: falling select on pin 0
        write_reg(2'd1, 4'h1);
        check_reg(2'd1, 4'h1, "R1 edge select readback");
        set_pins(4'b0111);
        settle();
        check_pend(4'h0, "R4 rising edge ignored");
        set_pins(4'b0110);
        settle();
        check_pend(4'h1, "R4 falling edge sets flag");
        check_wake(1'b0, "R8 pin 0 disabled");
        write_reg(2'd0, 4'hC);
        check_wake(1'b1, "R8 pin 0 enabled");
        write_reg(2'd2, 4'h1);
        check_pend(4'h0, "R6 clear pin 0");

        // R9: polarity change with steady pins
        write_reg(2'd1, 4'hD);
        settle();
        check_pend(4'h0, "R9 select change no event");
        write_reg(2'd1, 4'h1);
        settle();
        check_pend(4'h0, "R9 select restore no event");
        check_wake(1'b0, "R9 wake stays low");

        // R7: set and clear in the same cycle on pin 3
        set_pins(4'b1110);
        settle();
        check_pend(4'h8, "R3 pin 3 rising edge");
        set_pins(4'b0110);
        settle();
        check_pend(4'h8, "R3 pin 3 fall keeps flag");
        set_pins(4'b1110);
        @(negedge clk);
        @(negedge clk);
        we = 1'b1;
        addr = 2'd2;
        wdata = 4'h8;
        @(negedge clk);
        we = 1'b0;
        #1;
        expect_now(1, 4'h8, "R7 new edge beats clear");
        write_reg(2'd2, 4'h8);
        check_pend(4'h0, "R6 later clear works");

        // R1: all four pins at once
        write_reg(2'd1, 4'h0);
        set_pins(4'b0000);
        settle();
        check_pend(4'h0, "R3 all falls ignored");
        set_pins(4'b1111);
        settle();
        check_pend(4'hF, "R1 four simultaneous edges");
        check_wake(1'b1, "R8 wake with enabled pins");

        #20;
        done = 1'b1;
        report();
        $finish;
    end
endmodule